// File: doc/BRIEF.md
# Fall-through handshake FIFO

A first-in first-out buffer, 16 words deep and 4 bits wide by default. Each storage stage carries its own marker bit, and a word moves toward the output by itself, one stage per clock. It moves only into a stage that was empty at the start of that cycle. A producer loads a word with a rising edge on the shift-in strobe. A consumer discards the word at the output with a falling edge on the shift-out strobe.

Both strobes pass through two-flop synchronisers into the system clock before their edges are detected. Two flags report the state of the buffer. Input-ready is high while the first stage is free. Output-ready is high while the last stage holds a valid word. An output-disable input puts the data outputs in high impedance and holds back unloading.

A master reset clears only the marker bits, so the stored words stay in place but count as invalid. Two instances can be chained into a longer buffer. The upstream output-ready drives the downstream shift-in, and the downstream input-ready drives the upstream shift-out.

Top module: `ripple_fifo`

## Requirements
- R1: While master reset is high at a clock edge, every marker clears. After that edge input-ready reads 1 and output-ready reads 0.
- R2: Master reset leaves the stored words untouched, so the word last seen on the data output is still shown after reset. A word loaded after reset replaces it.
- R3: A word is loaded only on a rising edge of shift-in seen while input-ready is high. Input-ready then drops low, and it comes back high once the word has left the first stage, provided room remains.
- R4: Words come out in the order they were loaded. Output-ready rises once the oldest valid word reaches the last stage.
- R5: With all 16 stages valid, input-ready stays low and further shift-in edges load nothing. A full buffer stays full until a word is unloaded.
- R6: A falling edge of shift-out while output-ready is high discards the output word. Output-ready drops low for at least one cycle, then the next word follows.
- R7: While the buffer is empty, output-ready stays low and shift-out edges have no effect.
- R8: While output-disable is high, the data outputs are high impedance and no word is unloaded, even if shift-out falls.
- R9: If output-disable falls while shift-out is already low, the output word is unloaded at once and is lost.
- R10: Two chained instances pass a 32-word stream in its original order. In the chain, the upstream output-ready drives the downstream shift-in and the downstream input-ready drives the upstream shift-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Master reset, active high; clears the marker bits |
| shift_in | input | 1 | Load strobe; a rising edge loads a word |
| data_in | input | WIDTH | Word to load |
| in_ready | output | 1 | High while the first stage can take a word |
| shift_out | input | 1 | Unload strobe; a falling edge discards the output word |
| out_disable | input | 1 | High puts data_out in high impedance and blocks unloading |
| data_out | output | WIDTH | Word in the last stage |
| out_ready | output | 1 | High while the last stage holds a valid word |

## Verification
The bench builds the main instance with DEPTH 16 and WIDTH 4. At that size sixteen loads reach the full boundary, where a seventeenth edge must be dropped, and each word's value shows its place in the order. Two further 16 by 4 instances are chained, so a 32-word stream exercises the flag-to-strobe coupling and order across both buffers. The full and empty edges, the output-disable unload, and a reset with words held inside are all driven at that default depth.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    // Three-flop strobe pipeline: two synchroniser stages plus one edge stage.
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

endpackage

// File: rtl/rf_strobe_sync.sv
module rf_strobe_sync
    import ripple_fifo_pkg::*;
#(
    parameter bit FALLING   = 1'b0,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic mreset,
    input  logic strobe,
    output logic hit
);

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (mreset) begin
            sync_d = '{s1: RESET_VAL, s2: RESET_VAL, s3: RESET_VAL};
        end else begin
            sync_d.s1 = strobe;
            sync_d.s2 = sync_q.s1;
            sync_d.s3 = sync_q.s2;
        end
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign hit = sync_q.s3 & ~sync_q.s2;
        end else begin : g_rise
            assign hit = sync_q.s2 & ~sync_q.s3;
        end
    endgenerate

endmodule

// File: rtl/rf_stage_chain.sv
module rf_stage_chain #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             unload,
    output logic [DEPTH-1:0] mark,
    output logic [WIDTH-1:0] last_word
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0]            mark;
        logic [DEPTH-1:0][WIDTH-1:0] word;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (mreset) begin
            // Only the markers clear; stored words stay as they are.
            chain_d.mark = '0;
        end else begin
            // Ripple: a stage advances only into a neighbour empty at cycle start.
            for (int k = 0; k < LAST; k++) begin
                if (chain_q.mark[k] && !chain_q.mark[k+1]) begin
                    chain_d.mark[k+1] = 1'b1;
                    chain_d.word[k+1] = chain_q.word[k];
                    chain_d.mark[k]   = 1'b0;
                end
            end
            if (unload && chain_q.mark[LAST]) begin
                chain_d.mark[LAST] = 1'b0;
            end
            if (load && !chain_q.mark[0]) begin
                chain_d.mark[0] = 1'b1;
                chain_d.word[0] = load_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign mark      = chain_q.mark;
    assign last_word = chain_q.word[LAST];

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             in_ready,
    input  logic             shift_out,
    input  logic             out_disable,
    output logic [WIDTH-1:0] data_out,
    output logic             out_ready
);

    localparam int LAST = DEPTH - 1;

    logic             si_rise;
    logic             so_fall;
    logic             accept;
    logic             unload;
    logic [DEPTH-1:0] mark;
    logic [WIDTH-1:0] last_word;
    logic             unload_strobe;

    // Output-disable held high masks a falling shift-out; its own fall while
    // shift-out is low looks like a falling strobe and unloads the word.
    assign unload_strobe = shift_out | out_disable;

    rf_strobe_sync #(.FALLING(1'b0), .RESET_VAL(1'b0)) u_si_sync (
        .clk    (clk),
        .mreset (mreset),
        .strobe (shift_in),
        .hit    (si_rise)
    );

    rf_strobe_sync #(.FALLING(1'b1), .RESET_VAL(1'b1)) u_so_sync (
        .clk    (clk),
        .mreset (mreset),
        .strobe (unload_strobe),
        .hit    (so_fall)
    );

    assign in_ready  = ~mark[0];
    assign out_ready = mark[LAST];
    assign accept    = si_rise & in_ready;
    assign unload    = so_fall & out_ready;

    rf_stage_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .mreset    (mreset),
        .load      (accept),
        .load_word (data_in),
        .unload    (unload),
        .mark      (mark),
        .last_word (last_word)
    );

    assign data_out = out_disable ? {WIDTH{1'bz}} : last_word;

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             mreset,
    input logic             in_ready,
    input logic             out_ready,
    input logic             out_disable,
    input logic             accept,
    input logic             unload,
    input logic [DEPTH-1:0] mark
);

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        $past(mreset) |-> (in_ready && !out_ready));

    // R3
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (mreset)
        accept |=> !in_ready);

    // R4
    ready_holds_chk: assert property (@(posedge clk) disable iff (mreset)
        (out_ready && !unload) |=> out_ready);

    // R5
    full_stays_chk: assert property (@(posedge clk) disable iff (mreset)
        ((&mark) && !unload) |=> (&mark));

    // R6
    unload_drops_ready_chk: assert property (@(posedge clk) disable iff (mreset)
        unload |=> !out_ready);

    // R7
    empty_no_ready_chk: assert property (@(posedge clk) disable iff (mreset)
        !(|mark) |=> !out_ready);

    // R8
    disable_blocks_chk: assert property (@(posedge clk) disable iff (mreset)
        (out_disable && $past(out_disable) && $past(out_disable, 2)
         && $past(out_disable, 3)) |-> !unload);

endmodule

bind ripple_fifo rf_checker #(.DEPTH(DEPTH)) u_rf_checker (
    .clk         (clk),
    .mreset      (mreset),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_disable (out_disable),
    .accept      (accept),
    .unload      (unload),
    .mark        (mark)
);

// File: tb/ripple_fifo_bench.sv
`timescale 1ns/1ps
module ripple_fifo_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       mreset = 1'b1;
    logic       si = 1'b0;
    logic [3:0] din = '0;
    logic       so = 1'b1;
    logic       od = 1'b0;
    wire        in_ready;
    wire        out_ready;
    wire  [3:0] dout;

    ripple_fifo #(.DEPTH(16), .WIDTH(4)) u_ripple_fifo (
        .clk(clk), .mreset(mreset), .shift_in(si), .data_in(din),
        .in_ready(in_ready), .shift_out(so), .out_disable(od),
        .data_out(dout), .out_ready(out_ready)
    );

    // Chained pair for R10
    logic       a_si = 1'b0;
    logic [3:0] a_din = '0;
    logic       b_so = 1'b1;
    wire        a_in_ready, a_out_ready, b_in_ready, b_out_ready;
    wire  [3:0] a_dout, b_dout;

    ripple_fifo #(.DEPTH(16), .WIDTH(4)) u_casc_a (
        .clk(clk), .mreset(mreset), .shift_in(a_si), .data_in(a_din),
        .in_ready(a_in_ready), .shift_out(b_in_ready), .out_disable(1'b0),
        .data_out(a_dout), .out_ready(a_out_ready)
    );

    ripple_fifo #(.DEPTH(16), .WIDTH(4)) u_casc_b (
        .clk(clk), .mreset(mreset), .shift_in(a_out_ready), .data_in(a_dout),
        .in_ready(b_in_ready), .shift_out(b_so), .out_disable(1'b0),
        .data_out(b_dout), .out_ready(b_out_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0] exp_q[$];
    logic [3:0] casc_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Driver: load one word into the main instance, record it as expected.
    task automatic push(input logic [3:0] w, input bit expect_free);
        int n = 0;
        while (!in_ready && n < 100) begin @(negedge clk); n++; end
        din = w;
        si  = 1'b1;
        exp_q.push_back(w);
        n = 0;
        while (in_ready && n < 20) begin @(negedge clk); n++; end
        chk(!in_ready, "R3", in_ready, 0);
        si = 1'b0;
        if (expect_free) begin
            n = 0;
            while (!in_ready && n < 20) begin @(negedge clk); n++; end
            chk(in_ready, "R3", in_ready, 1);
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: wait for a word at the output, compare, then discard it.
    task automatic pop_check(input string tag);
        int n = 0;
        logic [3:0] e;
        while (!out_ready && n < 100) begin @(negedge clk); n++; end
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 4'h0;
        chk(out_ready && (dout == e), tag, dout, e);
        so = 1'b0;
        n = 0;
        while (out_ready && n < 20) begin @(negedge clk); n++; end
        chk(!out_ready, "R6", out_ready, 0);
        so = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        mreset = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(out_ready == 1'b0, "R1", out_ready, 0);

        // R7 shift-out pulse on an empty buffer
        so = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_ready == 1'b0, "R7", out_ready, 0);
        so = 1'b1;
        repeat (4) @(negedge clk);
        push(4'h5, 1'b1);
        pop_check("R4");
        repeat (10) @(negedge clk);
        chk(out_ready == 1'b0, "R7", out_ready, 0);

        // R5 fill to 16, then one ignored load
        for (int i = 0; i < 16; i++) push(4'((i * 7 + 3) & 15), i != 15);
        repeat (10) @(negedge clk);
        chk(in_ready == 1'b0, "R5", in_ready, 0);
        din = 4'hF;
        si  = 1'b1;
        repeat (6) @(negedge clk);
        si  = 1'b0;
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b0, "R5", in_ready, 0);
        for (int i = 0; i < 16; i++) pop_check("R4");
        repeat (10) @(negedge clk);
        chk(out_ready == 1'b0, "R5", out_ready, 0);

        // R8 blocked unload, R9 loss on output-disable fall
        push(4'h1, 1'b1);
        push(4'h2, 1'b1);
        while (!out_ready) @(negedge clk);
        od = 1'b1;
        repeat (2) @(negedge clk);
        so = 1'b0;
        repeat (8) @(negedge clk);
        chk(out_ready == 1'b1, "R8", out_ready, 1);
        od = 1'b0;
        begin
            int n = 0;
            while (out_ready && n < 20) begin @(negedge clk); n++; end
        end
        chk(out_ready == 1'b0, "R9", out_ready, 0);
        so = 1'b1;
        repeat (3) @(negedge clk);
        void'(exp_q.pop_front());
        pop_check("R9");

        // R2 reset keeps storage
        push(4'hC, 1'b1);
        while (!out_ready) @(negedge clk);
        chk(dout == 4'hC, "R4", dout, 12);
        mreset = 1'b1;
        repeat (2) @(negedge clk);
        mreset = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        chk(out_ready == 1'b0, "R1", out_ready, 0);
        chk(dout == 4'hC, "R2", dout, 12);
        exp_q.delete();
        push(4'h3, 1'b1);
        pop_check("R2");

        // R10 chained pair, 32 words
        fork
            begin
                for (int i = 0; i < 32; i++) begin
                    int n = 0;
                    while (!a_in_ready && n < 200) begin @(negedge clk); n++; end
                    a_din = 4'((i * 5 + 1) & 15);
                    casc_q.push_back(a_din);
                    a_si = 1'b1;
                    n = 0;
                    while (a_in_ready && n < 20) begin @(negedge clk); n++; end
                    a_si = 1'b0;
                    repeat (2) @(negedge clk);
                end
            end
            begin
                for (int i = 0; i < 32; i++) begin
                    int n = 0;
                    logic [3:0] e;
                    while (!b_out_ready && n < 400) begin @(negedge clk); n++; end
                    e = (casc_q.size() > 0) ? casc_q.pop_front() : 4'h0;
                    chk(b_out_ready && (b_dout == e), "R10", b_dout, e);
                    b_so = 1'b0;
                    n = 0;
                    while (b_out_ready && n < 20) begin @(negedge clk); n++; end
                    b_so = 1'b1;
                    repeat (2) @(negedge clk);
                end
            end
        join
        repeat (10) @(negedge clk);
        chk(b_out_ready == 1'b0, "R10", b_out_ready, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule